// File: doc/BRIEF.md
# Parallel Camera Capture Front-End

This block sits between a parallel image sensor and a word-wide capture FIFO. The sensor side has a pixel clock, a frame-valid strobe, a line-valid strobe and a 10-bit data bus. The block oversamples all of these in the system clock domain. It picks out the pixel-clock transition that software has chosen as active. At each active transition where both strobes are high, it hands one 16-bit word to the FIFO through a single-cycle push.

Capture never starts in the middle of a picture. When the enable control goes high, the block waits until it sees frame-valid go from low to high at a sampled active edge, and only then lets samples through. The sensor byte is always taken from the upper eight lines of the camera bus, and the two low lines are ignored. This works for an 8-bit sensor wired to the top of the bus, and it also reduces a 10-bit raw sample to its eight most significant bits. Every byte is zero-extended into its own word, whether the stream is raw Bayer or a byte-serial colour format. The word order follows the sensor byte order unchanged, and any colour handling is left to the host. While the FIFO reports overflow, nothing is pushed.

Top module: `cam_capture_front`

## Requirements
- R1: A word is pushed only for an active pixel-clock transition at which frame-valid and line-valid are both high. A transition with either strobe low pushes nothing.
- R2: Capture is armed only by a low-to-high change of frame-valid seen between two sampled active edges. An enable raised while a frame is in progress pushes nothing until the next frame begins. After reset, frame-valid is treated as already high, so a frame that is under way at reset is skipped.
- R3: When `cfg_fall_edge` is 0, only rising transitions of `cam_pclk` are active. When it is 1, only falling transitions are active. Data and strobes are taken as they stood just before the active transition.
- R4: The pushed word is `{8'h00, cam_d[9:2]}`. `cam_d[1:0]` has no effect on it.
- R5: If frame-valid rises at the same active edge at which line-valid is already high, that sample is pushed.
- R6: While `fifo_ovf` is 1 at an active edge, no push is made for that edge.
- R7: When `cfg_enable` is 0 at an active edge, no word is pushed. Capture must then re-arm at a later frame start.
- R8: `push` is high for exactly one clock cycle, from the third rising `clk` edge after the active `cam_pclk` transition. `push_data` is valid in the same cycle.
- R9: During and right after synchronous reset, `push` is 0 and `push_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the camera inputs |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Capture enable; takes effect at the next frame start |
| cfg_fall_edge | input | 1 | Active pixel-clock transition: 0 rising, 1 falling |
| fifo_ovf | input | 1 | FIFO overflow flag; blocks pushes while high |
| cam_pclk | input | 1 | Sensor pixel clock |
| cam_fv | input | 1 | Sensor frame-valid |
| cam_lv | input | 1 | Sensor line-valid |
| cam_d | input | 10 | Sensor data bus; byte on [9:2] |
| push | output | 1 | One-cycle FIFO write strobe |
| push_data | output | 16 | Word written to the FIFO |

## Verification
A push is due three rising clock edges after the active pixel-clock transition and lasts one cycle. Inputs are driven on falling clock edges and stay stable for two cycles before that transition and six cycles after it. For each stimulus, the bench counts pushes over a window of five falling edges, so each active edge must give exactly the expected number of words, with the expected value. Data changes midway through the inactive half-period. As a result, a capture on the wrong transition would return the previous vector's byte. One directed test checks the exact cycle in which the push appears and disappears.

// File: rtl/camcap_pkg.sv
package camcap_pkg;

    localparam int CAM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int BYTE_LSB = CAM_W - BYTE_W;

    // one oversampled camera sample, already reduced to the captured byte
    typedef struct packed {
        logic              fv;
        logic              lv;
        logic [BYTE_W-1:0] bval;
    } cam_sample_t;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_LIVE = 1'b1
    } arm_state_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CAM_W-1:0] d);
        return d[CAM_W-1 -: BYTE_W];
    endfunction

    function automatic logic [WORD_W-1:0] pad_word(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/cam_edge_sample.sv
module cam_edge_sample
    import camcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pclk_in,
    input  cam_sample_t smp_in,
    input  logic        fall_sel,
    output logic        evt,
    output cam_sample_t smp
);

    localparam int S = SYNC_STAGES;

    logic [S:0]  pclk_q;
    logic [S:0]  fill_q;
    cam_sample_t smp_q [S];

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q <= '0;
            fill_q <= '0;
        end else begin
            pclk_q <= {pclk_q[S-1:0], pclk_in};
            fill_q <= {fill_q[S-1:0], 1'b1};
        end
    end

    generate
        for (genvar i = 0; i < S; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) smp_q[i] <= '0;
                    else     smp_q[i] <= smp_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) smp_q[i] <= '0;
                    else     smp_q[i] <= smp_q[i-1];
                end
            end
        end
    endgenerate

    // transition between the two oldest pclk stages, in the chosen direction
    always_comb begin
        evt = fill_q[S] & (pclk_q[S-1] ^ pclk_q[S]) & (pclk_q[S-1] == ~fall_sel);
        smp = smp_q[S-1];
    end

endmodule

// File: rtl/cam_frame_arm.sv
module cam_frame_arm
    import camcap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic smp_fv,
    input  logic smp_lv,
    input  logic enable,
    output logic take
);

    arm_state_t state;
    logic       fv_prev;
    logic       frame_start;

    assign frame_start = smp_fv & ~fv_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ARM_IDLE;
            fv_prev <= 1'b1;   // assume a frame is already running
        end else begin
            if (!enable)
                state <= ARM_IDLE;
            else if (evt && frame_start)
                state <= ARM_LIVE;
            if (evt)
                fv_prev <= smp_fv;
        end
    end

    always_comb begin
        take = evt & enable & smp_fv & smp_lv &
               ((state == ARM_LIVE) | frame_start);
    end

    AST_ARM_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        (state == ARM_IDLE) && enable && evt && !(smp_fv && !fv_prev) |=> (state == ARM_IDLE)); // R2

endmodule

// File: rtl/cam_word_pack.sv
module cam_word_pack
    import camcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              ovf,
    input  logic [BYTE_W-1:0] bval,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            push      <= 1'b0;
            push_data <= '0;
        end else begin
            push <= take & ~ovf;
            if (take && !ovf)
                push_data <= pad_word(bval);
        end
    end

    AST_NO_PUSH_OVF: assert property (@(posedge clk) disable iff (rst)
        push |-> !$past(ovf)); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        push |-> (push_data[WORD_W-1:BYTE_W] == '0)); // R4

endmodule

// File: rtl/cam_capture_front.sv
module cam_capture_front
    import camcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_fall_edge,
    input  logic              fifo_ovf,
    input  logic              cam_pclk,
    input  logic              cam_fv,
    input  logic              cam_lv,
    input  logic [CAM_W-1:0]  cam_d,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);

    cam_sample_t raw_smp;
    cam_sample_t smp;
    logic        evt;
    logic        take;
    logic        unused_low_bits;

    assign raw_smp = '{fv: cam_fv, lv: cam_lv, bval: pick_byte(cam_d)};
    assign unused_low_bits = ^cam_d[BYTE_LSB-1:0];

    cam_edge_sample #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pclk_in  (cam_pclk),
        .smp_in   (raw_smp),
        .fall_sel (cfg_fall_edge),
        .evt      (evt),
        .smp      (smp)
    );

    cam_frame_arm u_arm (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .smp_fv (smp.fv),
        .smp_lv (smp.lv),
        .enable (cfg_enable),
        .take   (take)
    );

    cam_word_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .ovf       (fifo_ovf),
        .bval      (smp.bval),
        .push      (push),
        .push_data (push_data)
    );

    AST_PUSH_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(evt && smp.fv && smp.lv)); // R1
    AST_PUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(cfg_enable)); // R7
    AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !push); // R9

endmodule

// File: tb/cam_capture_front_tb.sv
`timescale 1ns/1ps
module cam_capture_front_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic        cfg_fall_edge = 1'b0;
    logic        fifo_ovf = 1'b0;
    logic        cam_pclk = 1'b0;
    logic        cam_fv = 1'b0;
    logic        cam_lv = 1'b0;
    logic [9:0]  cam_d = '0;
    logic        push;
    logic [15:0] push_data;

    int n_checks = 0;
    int n_errors = 0;
    int n_push   = 0;
    logic [15:0] last_word = '0;

    always #2 clk = ~clk;

    cam_capture_front u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_fall_edge(cfg_fall_edge),
        .fifo_ovf(fifo_ovf), .cam_pclk(cam_pclk), .cam_fv(cam_fv), .cam_lv(cam_lv),
        .cam_d(cam_d), .push(push), .push_data(push_data)
    );

    always @(negedge clk) begin
        if (push) begin
            n_push    = n_push + 1;
            last_word = push_data;
        end
    end

    typedef struct packed {
        logic       fall;
        logic       en;
        logic       ovf;
        logic       fv;
        logic       lv;
        logic [9:0] d;
        logic       exp;
        logic [7:0] eb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 8'h00}, // R2 idle before frame
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000, 1'b0, 8'h00}, // R1 frame start, no line
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h2A4, 1'b1, 8'hA9}, // R4
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h3FF, 1'b1, 8'hFF}, // R4
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h003, 1'b1, 8'h00}, // R4 low bits ignored
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'h155, 1'b0, 8'h00}, // R1 line gap
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h155, 1'b0, 8'h00}, // R6 overflow
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h154, 1'b1, 8'h55}, // R6 released
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'h0AA, 1'b0, 8'h00}, // R7 disabled
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h0AB, 1'b0, 8'h00}, // R2 mid-frame enable
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 8'h00}, // R2 frame gap
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h200, 1'b1, 8'h80}, // R5 start with line
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'h0F0, 1'b1, 8'h3C}, // R3 falling
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'h10C, 1'b1, 8'h43}, // R3 falling
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 8'h00}  // R1 frame end
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 9, 10: return "R2";
            2, 3, 4:  return "R4";
            6, 7:     return "R6";
            8:        return "R7";
            11:       return "R5";
            12, 13:   return "R3";
            default:  return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one pixel period: inactive level, new inputs, active level, settle window
    task automatic tick(input logic fall, input logic en, input logic ovf,
                        input logic fv, input logic lv, input logic [9:0] d);
        @(negedge clk);
        cfg_fall_edge = fall;
        cfg_enable    = en;
        fifo_ovf      = ovf;
        cam_pclk      = fall;
        repeat (2) @(negedge clk);
        cam_fv = fv;
        cam_lv = lv;
        cam_d  = d;
        repeat (2) @(negedge clk);
        cam_pclk = ~fall;
        repeat (5) @(negedge clk);
        #0.5;
    endtask

    task automatic run_check(input int exp_cnt, input logic [7:0] eb, input int base, input string req);
        check((n_push - base) == exp_cnt, req, n_push - base, exp_cnt);
        if (exp_cnt == 1)
            check(last_word == {8'h00, eb}, req, last_word, {8'h00, eb});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(push == 1'b0 && push_data == 16'h0, "R9", {15'h0, push, push_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        #0.5;
        check(push == 1'b0 && push_data == 16'h0, "R9", {15'h0, push, push_data}, 0);

        for (int i = 0; i < NV; i++) begin
            base = n_push;
            tick(VECS[i].fall, VECS[i].en, VECS[i].ovf, VECS[i].fv, VECS[i].lv, VECS[i].d);
            run_check(VECS[i].exp ? 1 : 0, VECS[i].eb, base, vec_req(i));
        end

        // R8: exact latency, rising mode; re-arm with a fresh frame start
        base = n_push;
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000);
        run_check(0, 8'h00, base, "R1");
        @(negedge clk);
        cam_pclk = 1'b0;
        repeat (2) @(negedge clk);
        cam_lv = 1'b1;
        cam_d  = 10'h0C8;
        repeat (2) @(negedge clk);
        cam_pclk = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(push == 1'b0, "R8", push, 0);
        @(posedge clk);
        #1;
        check(push == 1'b1 && push_data == 16'h0032, "R8", {push, push_data}, 17'h10032);
        @(posedge clk);
        #1;
        check(push == 1'b0, "R8", push, 0);

        // R2: reset during a running line, enabled; first frame is skipped
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        base = n_push;
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h1F0);
        run_check(0, 8'h00, base, "R2");
        base = n_push;
        tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000);
        run_check(0, 8'h00, base, "R2");
        base = n_push;
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h1F0);
        run_check(1, 8'h7C, base, "R2");

        // R7: enable dropped and raised mid-frame does not resume capture
        base = n_push;
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'h111);
        run_check(0, 8'h00, base, "R7");
        base = n_push;
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h112);
        run_check(0, 8'h00, base, "R7");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule